// File: doc/BRIEF.md
# Speaker Load Status Logic

This block forms the two status bits that a multi-channel speaker amplifier reports for each output channel. While the amplifier starts up, it classifies the DC load on each channel from two comparator flags. One flag says the load looks like a line driver. The other says the output is open. The block stores the result as a two-bit code. After start-up has finished, an AC load test can be run while a test tone is applied. For each channel, the block counts the crossings of a peak-current threshold. It declares an AC-coupled load present once a fixed number of crossings has been seen.

The low status bit is shared between the two tests. While the AC test is running, it carries the AC detect result, and the stored DC code is left untouched. When the AC test is switched off, the low bit returns to the stored DC value. A single flag tells the reader whether the bit pair currently holds a DC code.

Top module: `spk_load_status`

## Requirements
- R1: After reset every stat_hi and stat_lo bit is 0 and dc_valid is 1.
- R2: The DC code for a channel is written as {stat_hi, stat_lo}: 2'b00 for a normal load (neither flag set), 2'b10 for a line-driver load (cmp_line only), and 2'b11 for an open load (cmp_open set). Open takes priority over line. While dc_valid is 1, the code 2'b01 never appears.
- R3: The DC code is captured at each clock edge where dc_en and startup_active are both 1. The new code appears on the outputs in the cycle after that edge. At all other times the stored code holds, whatever the comparator flags do.
- R4: The AC test is active exactly when ac_en and startup_done were both 1 at the previous clock edge. dc_valid is 0 while the AC test is active and 1 otherwise. When ac_en is set before startup_done, the test waits until startup_done rises.
- R5: While the AC test is active, each rising edge of a channel's synchronised cmp_peak counts as one crossing. A level that stays high counts once. The channel's detect bit is set after THRESH (default 3) crossings.
- R6: The crossing counter saturates at THRESH. Once set, the detect bit stays at 1 for as long as the test remains active.
- R7: Starting the AC test clears every crossing counter and every detect bit, so on the first active cycle stat_lo is all zero.
- R8: While the AC test is active, stat_lo shows the AC detect bits and stat_hi keeps showing the stored DC high bits.
- R9: When the AC test is switched off, stat_lo in the next cycle again shows the stored DC low bits, which the AC test did not change.
- R10: Peak crossings that occur while the AC test is inactive are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dc_en | input | 1 | DC load classification enable |
| startup_active | input | 1 | Amplifier start-up cycle in progress |
| startup_done | input | 1 | Amplifier start-up has completed |
| ac_en | input | 1 | AC load test enable |
| cmp_line | input | NCH | Per-channel line-driver load comparator flag (synchronous) |
| cmp_open | input | NCH | Per-channel open load comparator flag (synchronous) |
| cmp_peak | input | NCH | Per-channel peak-current comparator flag (asynchronous) |
| stat_hi | output | NCH | Per-channel high status bit (stored DC high bit) |
| stat_lo | output | NCH | Per-channel low status bit (DC low bit or AC detect bit) |
| dc_valid | output | 1 | 1 when the status bits hold DC codes |

## Verification
A stored DC code that is corrupted or overwritten shows up on stat_hi at once. It also shows up on stat_lo in the first cycle after the AC test ends, because that is when the stored low bit is put back on the port. A crossing counter that is miscounted, not cleared, or allowed to count while inactive shows up on stat_lo within three cycles of the crossing that should or should not complete the count. A count that leaks across tests shows up in the first active cycle of the next AC test, as a nonzero stat_lo.

// File: rtl/lds_pkg.sv
package lds_pkg;

    typedef enum logic [1:0] {
        LD_NORMAL = 2'b00,
        LD_LINE   = 2'b10,
        LD_OPEN   = 2'b11
    } ld_code_e;

    function automatic ld_code_e classify(input logic line_flag, input logic open_flag);
        if (open_flag) begin
            return LD_OPEN;
        end else if (line_flag) begin
            return LD_LINE;
        end
        return LD_NORMAL;
    endfunction

endpackage

// File: rtl/lds_sync.sv
module lds_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/lds_dc_class.sv
module lds_dc_class
    import lds_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture_i,
    input  logic [NCH-1:0] line_i,
    input  logic [NCH-1:0] open_i,
    output logic [NCH-1:0] hi_o,
    output logic [NCH-1:0] lo_o
);

    typedef struct packed {
        logic [NCH-1:0] hi;
        logic [NCH-1:0] lo;
    } dc_state_t;

    dc_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int ch = 0; ch < NCH; ch++) begin
            ld_code_e code;
            code = classify(line_i[ch], open_i[ch]);
            if (capture_i) begin
                state_d.hi[ch] = code[1];
                state_d.lo[ch] = code[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign hi_o = state_q.hi;
    assign lo_o = state_q.lo;

endmodule

// File: rtl/lds_ac_detect.sv
module lds_ac_detect #(
    parameter int NCH    = 4,
    parameter int THRESH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_req_i,
    input  logic [NCH-1:0] peak_i,
    output logic           active_o,
    output logic [NCH-1:0] det_o
);

    localparam int CNT_W = $clog2(THRESH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(THRESH);

    typedef struct packed {
        logic                      act;
        logic [NCH-1:0]            prev;
        logic [NCH-1:0][CNT_W-1:0] cnt;
        logic [NCH-1:0]            det;
    } ac_state_t;

    ac_state_t state_d, state_q;

    always_comb begin
        logic start;
        state_d      = state_q;
        state_d.act  = run_req_i;
        state_d.prev = peak_i;
        start        = run_req_i && !state_q.act;
        for (int ch = 0; ch < NCH; ch++) begin
            logic rise;
            rise = peak_i[ch] && !state_q.prev[ch];
            if (start) begin
                state_d.cnt[ch] = '0;
                state_d.det[ch] = 1'b0;
            end else if (state_q.act) begin
                if (rise && (state_q.cnt[ch] < CNT_MAX)) begin
                    state_d.cnt[ch] = state_q.cnt[ch] + 1'b1;
                end
                state_d.det[ch] = (state_d.cnt[ch] == CNT_MAX);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign active_o = state_q.act;
    assign det_o    = state_q.det;

endmodule

// File: rtl/spk_load_status.sv
module spk_load_status #(
    parameter int NCH         = 4,
    parameter int THRESH      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dc_en,
    input  logic           startup_active,
    input  logic           startup_done,
    input  logic           ac_en,
    input  logic [NCH-1:0] cmp_line,
    input  logic [NCH-1:0] cmp_open,
    input  logic [NCH-1:0] cmp_peak,
    output logic [NCH-1:0] stat_hi,
    output logic [NCH-1:0] stat_lo,
    output logic           dc_valid
);

    logic [NCH-1:0] peak_sync;
    logic [NCH-1:0] dc_hi;
    logic [NCH-1:0] dc_lo;
    logic [NCH-1:0] ac_det;
    logic           ac_active;

    lds_sync #(.W(NCH), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_peak),
        .sync_o  (peak_sync)
    );

    lds_dc_class #(.NCH(NCH)) i_dc (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (dc_en && startup_active),
        .line_i    (cmp_line),
        .open_i    (cmp_open),
        .hi_o      (dc_hi),
        .lo_o      (dc_lo)
    );

    lds_ac_detect #(.NCH(NCH), .THRESH(THRESH)) i_ac (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_req_i (ac_en && startup_done),
        .peak_i    (peak_sync),
        .active_o  (ac_active),
        .det_o     (ac_det)
    );

    assign stat_hi  = dc_hi;
    assign stat_lo  = ac_active ? ac_det : dc_lo;
    assign dc_valid = !ac_active;

endmodule

// File: rtl/lds_checker.sv
module lds_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           dc_en,
    input logic           startup_active,
    input logic           startup_done,
    input logic           ac_en,
    input logic [NCH-1:0] stat_hi,
    input logic [NCH-1:0] stat_lo,
    input logic           dc_valid
);

    // R2: no 01 code while DC codes are shown
    p_no_invalid_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dc_valid |-> ((~stat_hi & stat_lo) == '0));

    // R3: high bits change only after a capture edge
    p_hold_outside_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(dc_en && startup_active)) |-> $stable(stat_hi));

    // R4: validity follows the registered enable condition
    p_valid_follows_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dc_valid == !$past(ac_en && startup_done));

    // R7: the first active cycle shows cleared detect bits
    p_cleared_on_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dc_valid) |-> (stat_lo == '0));

    // R6: a detect bit does not drop while the test stays active
    p_detect_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dc_valid && $past(!dc_valid)) |-> (($past(stat_lo) & ~stat_lo) == '0));

endmodule

bind spk_load_status lds_checker #(.NCH(NCH)) i_lds_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .dc_en          (dc_en),
    .startup_active (startup_active),
    .startup_done   (startup_done),
    .ac_en          (ac_en),
    .stat_hi        (stat_hi),
    .stat_lo        (stat_lo),
    .dc_valid       (dc_valid)
);

// File: tb/test_spk_load_status.sv
`timescale 1ns/1ps
module test_spk_load_status;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           dc_en = 1'b0;
    logic           startup_active = 1'b0;
    logic           startup_done = 1'b0;
    logic           ac_en = 1'b0;
    logic [NCH-1:0] cmp_line = '0;
    logic [NCH-1:0] cmp_open = '0;
    logic [NCH-1:0] cmp_peak = '0;
    logic [NCH-1:0] stat_hi;
    logic [NCH-1:0] stat_lo;
    logic           dc_valid;

    int checks = 0;
    int errors = 0;
    logic [NCH-1:0] exp_hi = '0;
    logic [NCH-1:0] exp_lo = '0;

    always #5 clk = ~clk;

    spk_load_status #(.NCH(NCH)) i_spk_load_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .dc_en          (dc_en),
        .startup_active (startup_active),
        .startup_done   (startup_done),
        .ac_en          (ac_en),
        .cmp_line       (cmp_line),
        .cmp_open       (cmp_open),
        .cmp_peak       (cmp_peak),
        .stat_hi        (stat_hi),
        .stat_lo        (stat_lo),
        .dc_valid       (dc_valid)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [NCH-1:0] hi_e,
                         input logic [NCH-1:0] lo_e, input logic valid_e);
        checks++;
        if (stat_hi !== hi_e || stat_lo !== lo_e || dc_valid !== valid_e) begin
            errors++;
            $display("FAIL %s: hi=%b lo=%b valid=%b expected hi=%b lo=%b valid=%b",
                     req, stat_hi, stat_lo, dc_valid, hi_e, lo_e, valid_e);
        end
    endtask

    task automatic pulse(input logic [NCH-1:0] mask, input int high_cycles);
        cmp_peak = mask;
        tick(high_cycles);
        cmp_peak = '0;
        tick(4);
    endtask

    task automatic t_reset;
        check("R1 reset state", '0, '0, 1'b1);
    endtask

    task automatic t_dc_capture;
        dc_en = 1'b1;
        startup_active = 1'b1;
        cmp_line = 4'b1010;
        cmp_open = 4'b1100;
        tick(1);
        exp_hi = 4'b1110;
        exp_lo = 4'b1100;
        check("R2 encoding with open over line", exp_hi, exp_lo, 1'b1);
        cmp_line = 4'b0001;
        cmp_open = 4'b0010;
        tick(1);
        exp_hi = 4'b0011;
        exp_lo = 4'b0010;
        check("R3 recapture next cycle", exp_hi, exp_lo, 1'b1);
        cmp_line = 4'b1000;
        cmp_open = 4'b0001;
        tick(1);
        exp_hi = 4'b1001;
        exp_lo = 4'b0001;
        check("R2 second pattern", exp_hi, exp_lo, 1'b1);
        startup_active = 1'b0;
        cmp_line = 4'b0110;
        cmp_open = 4'b0110;
        tick(3);
        check("R3 hold after startup", exp_hi, exp_lo, 1'b1);
        dc_en = 1'b0;
        startup_active = 1'b1;
        tick(3);
        check("R3 hold while disabled", exp_hi, exp_lo, 1'b1);
        startup_active = 1'b0;
        cmp_line = '0;
        cmp_open = '0;
        tick(1);
    endtask

    task automatic t_ac_wait_and_ignore;
        ac_en = 1'b1;
        tick(2);
        check("R4 waits for startup_done", exp_hi, exp_lo, 1'b1);
        pulse(4'b1111, 2);
        pulse(4'b1111, 2);
        pulse(4'b1111, 2);
        check("R10 inactive crossings not shown", exp_hi, exp_lo, 1'b1);
        startup_done = 1'b1;
        tick(1);
        check("R7 cleared on start, R4 active", exp_hi, 4'b0000, 1'b0);
        pulse(4'b0001, 2);
        pulse(4'b0001, 2);
        check("R10 earlier crossings not counted", exp_hi, 4'b0000, 1'b0);
    endtask

    task automatic t_ac_count;
        pulse(4'b0001, 2);
        check("R5 detect after third crossing, R8 hi kept", exp_hi, 4'b0001, 1'b0);
        pulse(4'b0010, 12);
        pulse(4'b0010, 1);
        check("R5 held level counts once", exp_hi, 4'b0001, 1'b0);
        pulse(4'b0010, 3);
        check("R5 third crossing on ch1", exp_hi, 4'b0011, 1'b0);
        pulse(4'b0011, 2);
        pulse(4'b0011, 2);
        check("R6 saturated detect stays", exp_hi, 4'b0011, 1'b0);
    endtask

    task automatic t_ac_disable;
        ac_en = 1'b0;
        tick(1);
        check("R9 stored DC low bits restored", exp_hi, exp_lo, 1'b1);
        ac_en = 1'b1;
        tick(1);
        check("R7 re-enable clears detect", exp_hi, 4'b0000, 1'b0);
        pulse(4'b1000, 2);
        check("R5 single crossing after restart", exp_hi, 4'b0000, 1'b0);
        ac_en = 1'b0;
        tick(1);
        check("R9 restore after second test", exp_hi, exp_lo, 1'b1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_dc_capture();
        t_ac_wait_and_ignore();
        t_ac_count();
        t_ac_disable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule